// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes one or two SDRAM device banks from power-up to normal operation. A controller presents one step of the bring-up at a time as a command code and a two-bit bank mask. The block accepts the step only while its busy flag is low. It then drives that step onto a shared SDRAM command bus: clock enable, chip selects, RAS, CAS, WE, bank address and row address. Busy stays high until the step's minimum recovery time has elapsed, and only then can the next step be accepted.

The expected order is as follows. Clock enable comes first, followed by the power-up wait. Then comes precharge-all, then a burst of auto-refreshes whose length is set by a count field, then the mode-register load. Last is the switch to normal operation, which arms a periodic refresh timer for the banks it targets. All timing gaps are counted in clock cycles from programmable 4-bit fields. The power-up wait uses a cycle count computed from the clock frequency.

Top module: `sdr_init_seq`

## Requirements
- R1: After reset, busy is low, both clock enables are low, and the bus carries NOP. NOP means both chip selects low with RAS, CAS and WE high.
- R2: Mode code 1 (clock enable) raises `sd_cke` for the masked banks in the cycle after acceptance. Clock enables never fall again. Busy stays high for `PWRUP_CYC` cycles.
- R3: Mode code 2 (precharge-all) drives a one-cycle command with RAS low, CAS high, WE low and address bit 10 high. Busy stays high for `cfg_trp`+1 cycles.
- R4: Mode code 3 (auto-refresh) issues `cmd_nrfs`+1 refresh commands. Each has RAS low, CAS low and WE high, and consecutive ones start `cfg_trc`+1 cycles apart. Busy stays high for (`cmd_nrfs`+1)·(`cfg_trc`+1) cycles.
- R5: Mode code 4 (load mode register) drives RAS, CAS and WE all low with bank address 0. The address carries burst length `cfg_bl` in bits [2:0] and CAS latency `cfg_cas` in bits [6:4], with all other bits 0. Busy stays high for `cfg_tmrd`+1 cycles.
- R6: A command presented while busy is high is ignored and never reaches the bus.
- R7: Mode codes 5, 6 and 7 are rejected. Busy stays low, the bus stays NOP and the clock enables are unchanged.
- R8: Mode code 0 (normal) holds busy for one cycle and loads the refresh timer with `cfg_refcnt`. From then on, an auto-refresh to every bank entered into normal mode is issued every `cfg_refcnt`+1 cycles. Each of these holds busy for `cfg_trc`+1 cycles.
- R9: Whenever busy is low, the bus carries NOP.
- R10: Mask bit 0 selects bank 1 (`sd_cs_n[0]`) and mask bit 1 selects bank 2 (`sd_cs_n[1]`). During a command, selected banks have chip select low and unselected ones high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_mode | input | 3 | Command code (0 normal, 1 clock enable, 2 precharge-all, 3 auto-refresh, 4 load mode) |
| cmd_target | input | 2 | Bank mask, bit 0 bank 1, bit 1 bank 2 |
| cmd_nrfs | input | 4 | Auto-refresh count minus one |
| cfg_cas | input | 3 | CAS latency for the mode word |
| cfg_bl | input | 3 | Burst length code for the mode word |
| cfg_tmrd | input | 4 | Mode-load recovery, cycles minus one |
| cfg_trp | input | 4 | Precharge recovery, cycles minus one |
| cfg_trc | input | 4 | Refresh cycle time, cycles minus one |
| cfg_refcnt | input | RW | Refresh period minus one |
| busy | output | 1 | Step in progress |
| sd_cke | output | 2 | Clock enable per bank |
| sd_cs_n | output | 2 | Chip select per bank, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BAW | Bank address |
| sd_addr | output | AW | Address lines |

## Verification
The bench stamps every bus command with its cycle and matches it against a queue of expected commands. An auto-refresh burst with an off-by-one count or spacing would therefore show up as a missing, extra or late refresh. It probes a request made in the middle of the power-up wait; a design that ignored busy would put a stray precharge on the bus. It sends the unsupported codes, which a loose decoder would execute or use to stall busy. It checks that periodic refreshes after normal entry reach only the bank that entered normal mode, at the programmed period, so a timer that reloaded late or selected both banks is caught. It also checks the mode word bit positions and the A10 level on precharge.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [2:0] {
    OP_RUN  = 3'd0,
    OP_CKE  = 3'd1,
    OP_PALL = 3'd2,
    OP_AREF = 3'd3,
    OP_LMR  = 3'd4,
    OP_SREF = 3'd5,
    OP_PDWN = 3'd6,
    OP_RSV  = 3'd7
  } sdr_op_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] RCW_NOP  = 3'b111;
  localparam logic [2:0] RCW_PALL = 3'b010;
  localparam logic [2:0] RCW_AREF = 3'b001;
  localparam logic [2:0] RCW_LMR  = 3'b000;

  function automatic logic op_supported(input sdr_op_e op);
    return (op == OP_RUN) || (op == OP_CKE) || (op == OP_PALL) ||
           (op == OP_AREF) || (op == OP_LMR);
  endfunction

  // Busy cycles of the first segment of a step.
  function automatic int unsigned first_span(input sdr_op_e op,
                                             input logic [3:0] trp,
                                             input logic [3:0] trc,
                                             input logic [3:0] tmrd,
                                             input int unsigned pwrup);
    case (op)
      OP_CKE:  return pwrup;
      OP_PALL: return int'(trp) + 1;
      OP_AREF: return int'(trc) + 1;
      OP_LMR:  return int'(tmrd) + 1;
      default: return 1;
    endcase
  endfunction

  // Mode word: burst length in [2:0], CAS latency in [6:4].
  function automatic logic [15:0] mode_word(input logic [2:0] cas,
                                            input logic [2:0] bl);
    return {9'd0, cas, 1'b0, bl};
  endfunction

endpackage

// File: rtl/sdr_step_engine.sv
module sdr_step_engine
  import sdr_init_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned PWRUP_CYC = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  sdr_op_e    op,
  input  logic [1:0] target,
  input  logic [3:0] nrfs,
  input  logic [3:0] trp,
  input  logic [3:0] trc,
  input  logic [3:0] tmrd,
  input  logic       ref_fire,
  input  logic [1:0] ref_mask,
  output logic       busy,
  output logic       issue,
  output sdr_op_e    issue_op,
  output logic [1:0] issue_mask
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    reps_q;
  logic [1:0]    mask_q;
  logic          seg_end;
  int unsigned   span;

  assign busy    = busy_q;
  assign seg_end = busy_q && (cnt_q == '0);
  assign span    = first_span(op, trp, trc, tmrd, PWRUP_CYC);

  always_comb begin
    issue      = 1'b0;
    issue_op   = OP_RUN;
    issue_mask = mask_q;
    if (accept) begin
      issue      = 1'b1;
      issue_op   = op;
      issue_mask = target;
    end else if (ref_fire) begin
      issue      = 1'b1;
      issue_op   = OP_AREF;
      issue_mask = ref_mask;
    end else if (seg_end && (reps_q != '0)) begin
      issue      = 1'b1;
      issue_op   = OP_AREF;
      issue_mask = mask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      reps_q <= '0;
      mask_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(span - 1);
      reps_q <= (op == OP_AREF) ? nrfs : 4'd0;
      mask_q <= target;
    end else if (ref_fire) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(trc);
      reps_q <= '0;
      mask_q <= ref_mask;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (reps_q != '0) begin
        reps_q <= reps_q - 1'b1;
        cnt_q  <= CW'(trc);
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int unsigned RW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    load_mask,
  input  logic          reload,
  input  logic [RW-1:0] period,
  output logic          due,
  output logic [1:0]    mask
);

  logic          en_q;
  logic [RW-1:0] cnt_q;
  logic [1:0]    mask_q;

  assign due  = en_q && (cnt_q == '0);
  assign mask = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (load) begin
      en_q   <= 1'b1;
      cnt_q  <= period;
      mask_q <= mask_q | load_mask;
    end else if (reload) begin
      cnt_q <= period;
    end else if (en_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sdr_cmd_encoder.sv
module sdr_cmd_encoder
  import sdr_init_pkg::*;
#(
  parameter int unsigned AW  = 13,
  parameter int unsigned BAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  sdr_op_e        op,
  input  logic [1:0]     mask,
  input  logic [2:0]     cas,
  input  logic [2:0]     bl,
  output logic [1:0]     cke,
  output logic [1:0]     cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [BAW-1:0] ba,
  output logic [AW-1:0]  addr
);

  localparam logic [AW-1:0] A10 = AW'(1) << 10;

  logic [15:0] mw;
  assign mw = mode_word(cas, bl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke                   <= '0;
      cs_n                  <= '0;
      {ras_n, cas_n, we_n}  <= RCW_NOP;
      ba                    <= '0;
      addr                  <= '0;
    end else begin
      cs_n                 <= '0;
      {ras_n, cas_n, we_n} <= RCW_NOP;
      ba                   <= '0;
      addr                 <= '0;
      if (issue) begin
        case (op)
          OP_CKE: cke <= cke | mask;
          OP_PALL: begin
            cs_n                 <= ~mask;
            {ras_n, cas_n, we_n} <= RCW_PALL;
            addr                 <= A10;
          end
          OP_AREF: begin
            cs_n                 <= ~mask;
            {ras_n, cas_n, we_n} <= RCW_AREF;
          end
          OP_LMR: begin
            cs_n                 <= ~mask;
            {ras_n, cas_n, we_n} <= RCW_LMR;
            addr                 <= mw[AW-1:0];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_init_pkg::*;
#(
  parameter int unsigned AW        = 13,
  parameter int unsigned BAW       = 2,
  parameter int unsigned RW        = 13,
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PWRUP_US  = 200,
  parameter int unsigned PWRUP_CYC = CLK_MHZ * PWRUP_US
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_mode,
  input  logic [1:0]     cmd_target,
  input  logic [3:0]     cmd_nrfs,
  input  logic [2:0]     cfg_cas,
  input  logic [2:0]     cfg_bl,
  input  logic [3:0]     cfg_tmrd,
  input  logic [3:0]     cfg_trp,
  input  logic [3:0]     cfg_trc,
  input  logic [RW-1:0]  cfg_refcnt,
  output logic           busy,
  output logic [1:0]     sd_cke,
  output logic [1:0]     sd_cs_n,
  output logic           sd_ras_n,
  output logic           sd_cas_n,
  output logic           sd_we_n,
  output logic [BAW-1:0] sd_ba,
  output logic [AW-1:0]  sd_addr
);

  localparam int unsigned CW_RAW = $clog2(PWRUP_CYC + 1);
  localparam int unsigned CW     = (CW_RAW > 5) ? CW_RAW : 5;

  sdr_op_e    op;
  logic       accept;
  logic       ref_due;
  logic       ref_fire;
  logic [1:0] ref_mask;
  logic       issue;
  sdr_op_e    issue_op;
  logic [1:0] issue_mask;

  assign op       = sdr_op_e'(cmd_mode);
  assign accept   = cmd_valid && !busy && op_supported(op);
  assign ref_fire = ref_due && !busy && !accept;

  sdr_step_engine #(.CW(CW), .PWRUP_CYC(PWRUP_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(op),
    .target(cmd_target), .nrfs(cmd_nrfs), .trp(cfg_trp), .trc(cfg_trc),
    .tmrd(cfg_tmrd), .ref_fire(ref_fire), .ref_mask(ref_mask),
    .busy(busy), .issue(issue), .issue_op(issue_op), .issue_mask(issue_mask)
  );

  sdr_refresh_timer #(.RW(RW)) u_refresh (
    .clk(clk), .rst_n(rst_n), .load(accept && (op == OP_RUN)),
    .load_mask(cmd_target), .reload(ref_fire), .period(cfg_refcnt),
    .due(ref_due), .mask(ref_mask)
  );

  sdr_cmd_encoder #(.AW(AW), .BAW(BAW)) u_enc (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(issue_op),
    .mask(issue_mask), .cas(cfg_cas), .bl(cfg_bl), .cke(sd_cke),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .ba(sd_ba), .addr(sd_addr)
  );

endmodule

// File: rtl/sdr_init_seq_chk.sv
module sdr_init_seq_chk #(
  parameter int unsigned AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_mode,
  input logic          busy,
  input logic [1:0]    sd_cke,
  input logic [1:0]    sd_cs_n,
  input logic          sd_ras_n,
  input logic          sd_cas_n,
  input logic          sd_we_n,
  input logic [AW-1:0] sd_addr,
  input logic          accept,
  input logic          ref_due,
  input logic          ref_fire
);

  a_r9_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111 && sd_cs_n == 2'b00));

  a_r2_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sd_cke) & ~sd_cke) == 2'b00));

  a_r3_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
    ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b010) |-> sd_addr[10]);

  a_r10_cmd_selects: assert property (@(posedge clk) disable iff (!rst_n)
    ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) |-> (sd_cs_n != 2'b11));

  a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_mode > 3'd4 && !ref_due) |=> !busy);

  a_r4_aref_start: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_mode == 3'd3) |=> ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b001 && busy));

  a_r8_periodic_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b001 && busy));

endmodule

bind sdr_init_seq sdr_init_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
  .busy(busy), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .accept(accept), .ref_due(ref_due), .ref_fire(ref_fire)
);

// File: tb/sdr_init_seq_tb.sv
module sdr_init_seq_tb;

  localparam int PWR  = 40;
  localparam int TRP  = 2;
  localparam int TRC  = 3;
  localparam int TMRD = 1;
  localparam int REF  = 20;

  typedef struct {
    int         stamp;
    logic [1:0] cs;
    logic [2:0] rcw;
    logic [12:0] addr;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_mode = '0;
  logic [1:0]  cmd_target = '0;
  logic [3:0]  cmd_nrfs = '0;
  logic [2:0]  cfg_cas = 3'd3;
  logic [2:0]  cfg_bl = 3'd0;
  logic [3:0]  cfg_tmrd = 4'(TMRD);
  logic [3:0]  cfg_trp = 4'(TRP);
  logic [3:0]  cfg_trc = 4'(TRC);
  logic [12:0] cfg_refcnt = 13'(REF);
  logic        busy;
  logic [1:0]  sd_cke, sd_cs_n, sd_ba;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;

  int   cyc = 0;
  int   errs = 0;
  int   checks = 0;
  int   unexpected = 0;
  int   idle_bad = 0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_init_seq #(.PWRUP_CYC(PWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_target(cmd_target), .cmd_nrfs(cmd_nrfs), .cfg_cas(cfg_cas),
    .cfg_bl(cfg_bl), .cfg_tmrd(cfg_tmrd), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .cfg_refcnt(cfg_refcnt), .busy(busy),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic push(input int st, input logic [1:0] cs, input logic [2:0] rcw,
                      input logic [12:0] a, input string tag);
    exp_t e;
    e.stamp = st; e.cs = cs; e.rcw = rcw; e.addr = a; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares every non-NOP bus cycle against the queue head.
  always @(negedge clk) begin
    if (rst_n) begin
      if ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) begin
        if (q.size() == 0) begin
          unexpected++;
          chk(1'b0, "R6/R7 unexpected command", int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.stamp && sd_cs_n == e.cs &&
              {sd_ras_n, sd_cas_n, sd_we_n} == e.rcw && sd_addr == e.addr,
              $sformatf("%s cmd cyc/cs/rcw/addr=%0d/%b/%b/%h exp %0d/%b/%b/%h",
                        e.tag, cyc, sd_cs_n, {sd_ras_n, sd_cas_n, sd_we_n}, sd_addr,
                        e.stamp, e.cs, e.rcw, e.addr), cyc, e.stamp);
        end
      end else if (!busy && sd_cs_n != 2'b00) begin
        idle_bad++;
      end
    end
  end

  // Driver: pushes the expected bus commands, then measures busy.
  task automatic send(input logic [2:0] mode, input logic [1:0] tgt,
                      input logic [3:0] nrfs, input int span, input string tag,
                      input bit poke);
    int e0;
    int n;
    e0 = cyc + 1;
    case (mode)
      3'd2: push(e0, ~tgt, 3'b010, 13'h400, tag);
      3'd3: for (int i = 0; i <= int'(nrfs); i++)
              push(e0 + i * (TRC + 1), ~tgt, 3'b001, 13'h0, tag);
      3'd4: push(e0, ~tgt, 3'b000, {6'd0, cfg_cas, 1'b0, cfg_bl}, tag);
      default: ;
    endcase
    cmd_mode = mode; cmd_target = tgt; cmd_nrfs = nrfs; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      if (poke && n == 5) begin
        cmd_mode = 3'd2; cmd_target = 2'b11; cmd_valid = 1'b1;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(n == span, {tag, " busy length"}, n, span);
  endtask

  initial begin
    #(20000 * 10);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int e0;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(sd_cke == 2'b00, "R1 cke", sd_cke, 0);
    chk(sd_cs_n == 2'b00 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 nop",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);

    // R7 unsupported codes
    send(3'd5, 2'b01, 4'd0, 0, "R7 code5", 1'b0);
    send(3'd6, 2'b11, 4'd0, 0, "R7 code6", 1'b0);
    send(3'd7, 2'b10, 4'd0, 0, "R7 code7", 1'b0);
    chk(sd_cke == 2'b00, "R7 cke untouched", sd_cke, 0);

    // R2 clock enable bank 1, with an ignored request mid-wait (R6)
    send(3'd1, 2'b01, 4'd0, PWR, "R2 cke bank1", 1'b1);
    chk(sd_cke == 2'b01, "R2 R10 cke bank1 only", sd_cke, 1);
    repeat (3) @(negedge clk);
    chk(unexpected == 0 && q.size() == 0, "R6 busy request dropped", unexpected, 0);
    send(3'd1, 2'b10, 4'd0, PWR, "R2 cke bank2", 1'b0);
    chk(sd_cke == 2'b11, "R2 cke both", sd_cke, 3);

    // R3 precharge-all on both banks
    send(3'd2, 2'b11, 4'd0, TRP + 1, "R3 pall", 1'b0);
    // R4 auto-refresh bursts
    send(3'd3, 2'b01, 4'd3, 4 * (TRC + 1), "R4 aref x4 bank1", 1'b0);
    send(3'd3, 2'b10, 4'd0, TRC + 1, "R4 R10 aref x1 bank2", 1'b0);
    // R5 mode-register loads
    cfg_cas = 3'd3; cfg_bl = 3'd0;
    send(3'd4, 2'b11, 4'd0, TMRD + 1, "R5 lmr cas3", 1'b0);
    cfg_cas = 3'd2; cfg_bl = 3'd2;
    send(3'd4, 2'b01, 4'd0, TMRD + 1, "R5 lmr cas2 bl2", 1'b0);
    chk(q.size() == 0, "R4 R5 all commands seen", q.size(), 0);

    // R8 normal entry for bank 1 only
    e0 = cyc + 1;
    for (int k = 1; k <= 3; k++) push(e0 + k * (REF + 1), 2'b10, 3'b001, 13'h0, "R8 periodic");
    send(3'd0, 2'b01, 4'd0, 1, "R8 normal", 1'b0);
    while (cyc < e0 + REF + 1) @(negedge clk);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == TRC + 1, "R8 refresh busy", n, TRC + 1);
    while (cyc < e0 + 3 * (REF + 1) + 5) @(negedge clk);
    chk(q.size() == 0, "R8 refresh count", q.size(), 0);
    chk(idle_bad == 0, "R9 idle nop", idle_bad, 0);
    chk(sd_cke == 2'b11, "R2 cke held", sd_cke, 3);
    finish_run();
  end

endmodule